// File: doc/BRIEF.md
# Serial NAND Page Read Sequencer

This block is the host side of a serial flash link to a NAND device that holds an internal page buffer. A read request names a page, a starting column, a byte count and a read style. The sequencer turns the request into a series of SPI commands. It first sets the device's buffer-style bit if the requested style differs from the cached one. It then moves the page from the array into the device buffer and streams the requested bytes back as a byte-wide output with valid and last strobes.

Two read styles are offered. Buffer style starts at the requested column. Continuous style always starts at column 0 of the loaded page, and the device carries on into the following pages. After reset no command goes out until a power-up window has passed. During that window the device fills its buffer with page 0, so the first request for page 0 needs no load command. SCLK is the system clock divided by `CLK_DIV`. Its idle level follows a static mode input: low for mode 0, high for mode 3.

Top module: `nand_page_reader`

## Requirements
- R1: From reset release until `INIT_CYCLES` clock cycles have passed, `cs_n` stays high and `req_busy` stays high. A request made in that window is dropped.
- R2: While `cs_n` is low, `mosi` changes only on falling SCLK edges, so it is stable whenever SCLK is high. On every edge of `cs_n`, SCLK sits at its idle level: `mode3`=0 gives low and `mode3`=1 gives high.
- R3: If the first accepted request after reset is for page 0 and asks for buffer style, it sends only the read command and no page-load command.
- R4: Any other page (or page 0 after the first request) is loaded with opcode 0x13, then byte 0x00, then the page number high byte and low byte. No read command starts until at least `LOAD_CYCLES` clocks after `cs_n` rises at the end of the load.
- R5: In buffer style the read command is opcode 0x03, then the column high byte and low byte, then 0x00. The first data byte comes from the requested column.
- R6: In continuous style the column bytes of the read command are both 0x00 whatever column was requested. Data runs from column 0 and crosses page boundaries.
- R7: When the requested style differs from the cached style, a get-feature (0x0F, 0xB0, one byte read back) and a set-feature (0x1F, 0xB0, value) come before the page load. The value keeps every bit that was read back except bit 3, which is 1 for buffer style and 0 for continuous. When the style matches, neither command is sent. The style cached after reset is buffer.
- R8: Between any two commands, `cs_n` stays high for at least `GAP_SCLKS*CLK_DIV` clock cycles.
- R9: Exactly `req_len` bytes are delivered per request. `out_last` is high with the final byte only, and `cs_n` rises after that byte.
- R10: `req_busy` is high from the cycle after a request is accepted until the sequence ends, and `cs_n` is never low while `req_busy` is low. A request made while busy, or one with `req_len`=0, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode3 | input | 1 | Static SPI mode select: 0 idles SCLK low, 1 idles it high |
| req_valid | input | 1 | Request strobe, accepted when not busy |
| req_cont | input | 1 | 1 = continuous style, 0 = buffer style |
| req_page | input | 16 | Page number to read |
| req_col | input | 16 | Start column (buffer style only) |
| req_len | input | LEN_W | Number of bytes to deliver |
| req_busy | output | 1 | Sequence in progress or power-up window running |
| out_valid | output | 1 | Output byte strobe |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Marks the final byte of a request |
| sclk | output | 1 | SPI serial clock |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | Host-to-device serial data |
| miso | input | 1 | Device-to-host serial data |

## Verification
The bench attacks the skip rule for the page-load command from three sides: page 0 right after reset, page 0 later on, and page 0 after a style change. A design with a loose skip rule would read a stale buffer, and the streamed bytes would differ from the model's. Style changes are made in both directions, so a read-modify-write that drops the other feature bits, or a cached style that never updates, shows up as a wrong set-feature value or an extra or missing command. Continuous reads are made long enough to cross a page, with a nonzero requested column, so a design that forwards the column would start at the wrong byte. Both SPI modes are run. A mode-3 design that lets the clock fall at the chip-select edge, or that moves MOSI while the clock is high at the end of a command, is caught at those edges.

// File: rtl/nand_page_reader.sv
module nand_page_reader #(
  parameter int CLK_DIV     = 4,
  parameter int INIT_CYCLES = 50000,
  parameter int LOAD_CYCLES = 5000,
  parameter int GAP_SCLKS   = 2,
  parameter int LEN_W       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode3,
  input  logic             req_valid,
  input  logic             req_cont,
  input  logic [15:0]      req_page,
  input  logic [15:0]      req_col,
  input  logic [LEN_W-1:0] req_len,
  output logic             req_busy,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_last,
  output logic             sclk,
  output logic             cs_n,
  output logic             mosi,
  input  logic             miso
);

  localparam int HALF     = CLK_DIV / 2;
  localparam int DIV_W    = $clog2(HALF) + 1;
  localparam int GAP_CLKS = GAP_SCLKS * CLK_DIV;
  localparam int WAIT_W   = $clog2(INIT_CYCLES + LOAD_CYCLES + GAP_CLKS + 1) + 1;
  localparam int BW       = LEN_W + 2;

  typedef enum logic [2:0] {S_INIT, S_IDLE, S_LEAD, S_SHIFT, S_TRAIL, S_WAIT} state_t;
  typedef enum logic [1:0] {C_GETF, C_SETF, C_LOAD, C_READ} cmd_t;

  state_t            st;
  cmd_t              cmd, cmd_first, cmd_next;
  logic [WAIT_W-1:0] wcnt;
  logic [DIV_W-1:0]  div;
  logic              hi;
  logic [2:0]        bitc;
  logic [BW-1:0]     bidx, nxt_idx, tx_n, last_idx;
  logic [LEN_W-1:0]  rem, p_len;
  logic [7:0]        txsh, rxsh, cfg, tx_nxt;
  logic              cur_cont, fresh, p_cont;
  logic [15:0]       p_page, p_col, col_eff;
  logic              half_end, accept, mchg, load_needed;

  function automatic logic [7:0] opcode(input cmd_t c);
    case (c)
      C_GETF:  return 8'h0F;
      C_SETF:  return 8'h1F;
      C_LOAD:  return 8'h13;
      default: return 8'h03;
    endcase
  endfunction

  assign half_end    = (div == DIV_W'(HALF - 1));
  assign accept      = (st == S_IDLE) && req_valid && (req_len != '0);
  assign mchg        = (req_cont != cur_cont);
  assign load_needed = mchg || !(fresh && (req_page == 16'h0000));
  assign cmd_first   = mchg ? C_GETF : (load_needed ? C_LOAD : C_READ);
  assign cmd_next    = (cmd == C_GETF) ? C_SETF : ((cmd == C_SETF) ? C_LOAD : C_READ);
  assign col_eff     = p_cont ? 16'h0000 : p_col;
  assign nxt_idx     = bidx + BW'(1);
  assign tx_n        = (cmd == C_GETF) ? BW'(2) : ((cmd == C_SETF) ? BW'(3) : BW'(4));
  assign last_idx    = (cmd == C_READ) ? (BW'(3) + BW'(p_len)) :
                       ((cmd == C_LOAD) ? BW'(3) : BW'(2));

  always_comb begin
    tx_nxt = 8'h00;
    case (cmd)
      C_GETF: if (nxt_idx == BW'(1)) tx_nxt = 8'hB0;
      C_SETF: begin
        if (nxt_idx == BW'(1)) tx_nxt = 8'hB0;
        else if (nxt_idx == BW'(2)) tx_nxt = {cfg[7:4], ~p_cont, cfg[2:0]};
      end
      C_LOAD: begin
        if (nxt_idx == BW'(2)) tx_nxt = p_page[15:8];
        else if (nxt_idx == BW'(3)) tx_nxt = p_page[7:0];
      end
      default: begin
        if (nxt_idx == BW'(1)) tx_nxt = col_eff[15:8];
        else if (nxt_idx == BW'(2)) tx_nxt = col_eff[7:0];
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_INIT;  cmd <= C_READ;  wcnt <= WAIT_W'(INIT_CYCLES - 1);
      div <= '0;  hi <= 1'b0;  bitc <= '0;  bidx <= '0;  rem <= '0;
      txsh <= '0;  rxsh <= '0;  cfg <= '0;
      cur_cont <= 1'b0;  fresh <= 1'b1;
      p_cont <= 1'b0;  p_page <= '0;  p_col <= '0;  p_len <= '0;
      out_valid <= 1'b0;  out_data <= '0;  out_last <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      case (st)
        S_INIT: begin
          if (wcnt == '0) st <= S_IDLE;
          else wcnt <= wcnt - WAIT_W'(1);
        end
        S_IDLE: if (accept) begin
          p_cont <= req_cont;  p_page <= req_page;  p_col <= req_col;  p_len <= req_len;
          rem <= req_len;  fresh <= 1'b0;
          cmd <= cmd_first;  txsh <= opcode(cmd_first);
          st <= S_LEAD;  div <= '0;  bidx <= '0;  bitc <= '0;  hi <= 1'b0;
        end
        S_LEAD: begin
          if (half_end) begin div <= '0; st <= S_SHIFT; end
          else div <= div + DIV_W'(1);
        end
        S_SHIFT: begin
          if (!half_end) div <= div + DIV_W'(1);
          else begin
            div <= '0;
            if (!hi) begin
              hi   <= 1'b1;
              rxsh <= {rxsh[6:0], miso};
            end else begin
              hi   <= 1'b0;
              bitc <= bitc + 3'd1;
              if (bitc != 3'd7) txsh <= {txsh[6:0], 1'b0};
              else begin
                if (bidx >= tx_n) begin
                  if (cmd == C_GETF) cfg <= rxsh;
                  if (cmd == C_READ) begin
                    out_valid <= 1'b1;
                    out_data  <= rxsh;
                    out_last  <= (rem == LEN_W'(1));
                    rem       <= rem - LEN_W'(1);
                  end
                end
                if (bidx == last_idx) st <= S_TRAIL;
                else begin
                  bidx <= nxt_idx;
                  txsh <= tx_nxt;
                end
              end
            end
          end
        end
        S_TRAIL: begin
          if (half_end) begin
            div  <= '0;
            st   <= S_WAIT;
            wcnt <= (cmd == C_LOAD) ? WAIT_W'(LOAD_CYCLES + GAP_CLKS - 1) : WAIT_W'(GAP_CLKS - 1);
            if (cmd == C_SETF) cur_cont <= p_cont;
          end else div <= div + DIV_W'(1);
        end
        S_WAIT: begin
          if (wcnt != '0) wcnt <= wcnt - WAIT_W'(1);
          else if (cmd == C_READ) st <= S_IDLE;
          else begin
            cmd  <= cmd_next;  txsh <= opcode(cmd_next);
            st   <= S_LEAD;  div <= '0;  bidx <= '0;  bitc <= '0;  hi <= 1'b0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_busy = (st != S_IDLE);
  assign cs_n     = !((st == S_LEAD) || (st == S_SHIFT) || (st == S_TRAIL));
  assign sclk     = (st == S_SHIFT) ? hi : mode3;
  assign mosi     = cs_n ? 1'b0 : txsh[7];

endmodule

// File: rtl/nand_page_reader_chk.sv
module nand_page_reader_chk #(
  parameter int INIT_CYCLES = 50000
) (
  input logic clk,
  input logic rst_n,
  input logic mode3,
  input logic req_busy,
  input logic out_valid,
  input logic out_last,
  input logic sclk,
  input logic cs_n,
  input logic mosi
);

  int unsigned init_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) init_cnt <= 0;
    else if (init_cnt < INIT_CYCLES) init_cnt <= init_cnt + 1;
  end

  AST_INIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (init_cnt < INIT_CYCLES) |-> (cs_n && req_busy)); // R1

  AST_CS_EDGE_IDLE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n != $past(cs_n)) |-> ((sclk == mode3) && ($past(sclk) == mode3))); // R2

  AST_MOSI_HELD_HIGH_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !$past(cs_n) && sclk && $past(sclk)) |-> $stable(mosi)); // R2

  AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid); // R9

  AST_DATA_WHILE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !cs_n); // R9

  AST_SELECT_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !req_busy |-> cs_n); // R10

endmodule

bind nand_page_reader nand_page_reader_chk #(.INIT_CYCLES(INIT_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode3(mode3), .req_busy(req_busy),
  .out_valid(out_valid), .out_last(out_last), .sclk(sclk), .cs_n(cs_n), .mosi(mosi)
);

// File: tb/nand_page_reader_test.sv
module nand_page_reader_test;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_DIV    = 4;
  localparam int INIT_CYC   = 200;
  localparam int LOAD_CYC   = 120;
  localparam int GAP_SCLKS  = 2;
  localparam int GAP_CLKS   = GAP_SCLKS * CLK_DIV;
  localparam int PG         = 8;
  localparam int LEN_W      = 16;

  logic clk = 0, rst_n = 0, mode3 = 0;
  logic req_valid = 0, req_cont = 0;
  logic [15:0] req_page = 0, req_col = 0;
  logic [LEN_W-1:0] req_len = 0;
  logic req_busy, out_valid, out_last, sclk, cs_n, mosi, miso;
  logic [7:0] out_data;

  nand_page_reader #(.CLK_DIV(CLK_DIV), .INIT_CYCLES(INIT_CYC), .LOAD_CYCLES(LOAD_CYC),
                     .GAP_SCLKS(GAP_SCLKS), .LEN_W(LEN_W)) uut (
    .clk(clk), .rst_n(rst_n), .mode3(mode3), .req_valid(req_valid), .req_cont(req_cont),
    .req_page(req_page), .req_col(req_col), .req_len(req_len), .req_busy(req_busy),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, fall_count = 0, rise_cyc = 0;
  bit after_load = 0, finished = 0;
  logic prev_cs = 1, prev_sclk = 0, prev_mosi = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] dbyte(input int p, input int c);
    return 8'(p * 5 + c * 11 + 3);
  endfunction

  // device model
  logic miso_r = 0;
  assign miso = miso_r;
  int nb = 0, bitn = 0;
  logic [7:0] sh = 0, osh = 0, cur_op = 0, cfg_reg = 8'h18, setf_val = 0, gaddr = 0;
  logic [7:0] hdr [4];
  logic [15:0] load_field = 0, read_col_field = 0;
  int lp = 0, pg_m = 0, col_m = 0;
  bit bufm = 1;
  logic [7:0] ops [$];
  logic [8:0] exp_q [$];

  task automatic model_reset();
    cfg_reg = 8'h18; lp = 0; bufm = 1; cur_op = 0; ops.delete(); exp_q.delete();
  endtask

  task automatic take(input logic [7:0] b);
    if (nb == 0) begin cur_op = b; ops.push_back(b); end
    if (nb < 4) hdr[nb] = b;
    case (cur_op)
      8'h0F: if (nb == 1) begin gaddr = b; osh = cfg_reg; end
      8'h1F: begin
        if (nb == 1) gaddr = b;
        if (nb == 2) begin cfg_reg = b; setf_val = b; end
      end
      8'h13: if (nb == 3) begin load_field = {hdr[2], b}; lp = int'(load_field); bufm = cfg_reg[3]; end
      8'h03: begin
        if (nb == 3) begin
          read_col_field = {hdr[1], hdr[2]};
          col_m = bufm ? int'(read_col_field) : 0;
          pg_m = lp;
          osh = dbyte(pg_m, col_m);
        end else if (nb > 3) begin
          col_m++;
          if (!bufm && col_m == PG) begin col_m = 0; pg_m++; end
          osh = dbyte(pg_m, col_m);
        end
      end
      default: ;
    endcase
  endtask

  always @(negedge cs_n) begin nb = 0; bitn = 0; end

  always @(posedge sclk) if (cs_n === 1'b0) begin
    sh = {sh[6:0], mosi};
    bitn++;
    if (bitn == 8) begin bitn = 0; take(sh); nb++; end
  end

  always @(negedge sclk) if (cs_n === 1'b0) begin
    miso_r = osh[7];
    osh = {osh[6:0], 1'b0};
  end

  // per-cycle monitor against the reference
  always @(posedge clk) if (rst_n) cyc++; else cyc = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_cs = 1; prev_sclk = mode3; rise_cyc = 0; after_load = 0;
    end else begin
      if (out_valid) begin
        if (exp_q.size() == 0) chk(0, "R9 byte beyond count", out_data, 0);
        else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          chk(out_data == e[7:0], "R5 R6 data byte", out_data, e[7:0]);
          chk(out_last == e[8], "R9 last flag", out_last, e[8]);
        end
      end
      if (cs_n !== prev_cs) begin
        chk(sclk == mode3 && prev_sclk == mode3, "R2 clock idle at select edge", sclk, mode3);
        if (!cs_n) begin
          fall_count++;
          chk(cyc - rise_cyc >= GAP_CLKS, "R8 deselect gap", cyc - rise_cyc, GAP_CLKS);
          if (after_load) chk(cyc - rise_cyc >= LOAD_CYC, "R4 load wait", cyc - rise_cyc, LOAD_CYC);
          chk(cyc >= INIT_CYC, "R1 init window", cyc, INIT_CYC);
        end else begin
          rise_cyc = cyc;
          after_load = (cur_op == 8'h13);
        end
      end
      if (!cs_n && !prev_cs && sclk && prev_sclk)
        chk(mosi == prev_mosi, "R2 mosi stable while clock high", mosi, prev_mosi);
      if (!cs_n) chk(req_busy, "R10 busy while selected", req_busy, 1);
      prev_cs = cs_n; prev_sclk = sclk; prev_mosi = mosi;
    end
  end

  task automatic issue(input int pg, input int col, input int len, input bit cont);
    int p, c;
    @(negedge clk);
    while (req_busy) @(negedge clk);
    req_page = 16'(pg); req_col = 16'(col); req_len = LEN_W'(len); req_cont = cont;
    req_valid = 1;
    p = pg; c = cont ? 0 : col;
    for (int i = 0; i < len; i++) begin
      exp_q.push_back({(i == len - 1), dbyte(p, c)});
      c++;
      if (cont && c == PG) begin c = 0; p++; end
    end
    @(negedge clk);
    req_valid = 0;
    chk(req_busy, "R10 busy after accept", req_busy, 1);
  endtask

  task automatic finish_req(input int n, input logic [31:0] eops, input string tag);
    while (req_busy) @(negedge clk);
    chk(ops.size() == n, {tag, " command count"}, ops.size(), n);
    for (int i = 0; i < n && i < ops.size(); i++)
      chk(ops[i] == eops[31-8*i -: 8], {tag, " command opcode"}, ops[i], eops[31-8*i -: 8]);
    chk(exp_q.size() == 0, "R9 all bytes delivered", exp_q.size(), 0);
    ops.delete();
  endtask

  task automatic do_reset(input bit m3);
    rst_n = 0; mode3 = m3; model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cs_n == 1, "R1 reset cs_n high", cs_n, 1);
    chk(req_busy == 1, "R1 reset busy", req_busy, 1);
    chk(out_valid == 0, "R1 reset no output", out_valid, 0);
    chk(sclk == m3, "R2 reset clock idle", sclk, m3);
  endtask

  initial begin
    int fc;
    do_reset(0);
    // R1: request during power-up window is dropped
    repeat (10) @(negedge clk);
    req_page = 3; req_len = 2; req_valid = 1;
    @(negedge clk); req_valid = 0;
    while (req_busy) @(negedge clk);
    chk(fall_count == 0, "R1 no command during init", fall_count, 0);
    chk(cyc >= INIT_CYC, "R1 busy through init", cyc, INIT_CYC);
    chk(ops.size() == 0, "R1 dropped request", ops.size(), 0);

    // R3 + R5: fresh page 0 in buffer style
    issue(0, 3, 5, 0);
    finish_req(1, 32'h03000000, "R3");
    chk(read_col_field == 3, "R5 column field", read_col_field, 3);

    // R4 + R5: other page
    issue(9, 2, 4, 0);
    finish_req(2, 32'h13030000, "R4");
    chk(load_field == 9, "R4 page field", load_field, 9);
    chk(read_col_field == 2, "R5 column field", read_col_field, 2);

    // R10: zero-length request ignored
    fc = fall_count;
    @(negedge clk);
    req_len = 0; req_page = 4; req_valid = 1;
    @(negedge clk); req_valid = 0;
    repeat (20) @(negedge clk);
    chk(!req_busy, "R10 zero length ignored busy", req_busy, 0);
    chk(fall_count == fc, "R10 zero length ignored select", fall_count, fc);

    // R6 + R7: switch to continuous; R10 refusal while busy
    issue(2, 6, 12, 1);
    repeat (60) @(negedge clk);
    req_page = 7; req_col = 1; req_len = 3; req_cont = 0; req_valid = 1;
    @(negedge clk); req_valid = 0;
    finish_req(4, 32'h0F1F1303, "R7 R10");
    chk(setf_val == 8'h10, "R7 set value continuous", setf_val, 8'h10);
    chk(gaddr == 8'hB0, "R7 feature address", gaddr, 8'hB0);
    chk(read_col_field == 0, "R6 column field zero", read_col_field, 0);
    chk(load_field == 2, "R10 busy request not taken", load_field, 2);

    // R7 skip: same style again
    issue(5, 1, 3, 1);
    finish_req(2, 32'h13030000, "R7");

    // R3 corner + R7: page 0 later, back to buffer style
    issue(0, 7, 2, 0);
    finish_req(4, 32'h0F1F1303, "R3 R7");
    chk(setf_val == 8'h18, "R7 set value buffer", setf_val, 8'h18);
    chk(load_field == 0, "R3 page 0 reloaded", load_field, 0);

    // mode 3
    do_reset(1);
    while (req_busy) @(negedge clk);
    issue(0, 0, 2, 0);
    finish_req(1, 32'h03000000, "R2 R3");
    issue(4, 5, 10, 1);
    finish_req(4, 32'h0F1F1303, "R2 R6");
    chk(read_col_field == 0, "R6 column field zero mode 3", read_col_field, 0);

    repeat (20) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule